// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block provides the two digital dividers of one frequency synthesizer loop. The main path divides an oscillator tick stream by N = 64*B + A. It does this with a prescaler model that divides by 65 while an A counter is nonzero and by 64 otherwise. An 11-bit B counter counts the prescaler cycles. The reference path divides a reference tick stream by a 15-bit ratio R. Each path emits a single-cycle pulse once per period, which a phase detector can compare.

Both paths run on one system clock `clk_i`. Each input cycle of the divided signal appears as a one-clock strobe (`main_en_i`, `ref_en_i`). Ratios come from 24-bit configuration words that select bits steer to the main or reference register. A written ratio is held as pending and is loaded into the counters only at the end of the period in progress. Illegal values are forced to the smallest legal value, and `err_o` is raised.

Top module: `swd_top`

## Requirements
- R1: A word with bits [1:0]=01 programs the main ratio: A = bits [8:2], B = bits [19:9]. The main pulse then repeats every 64*B + A main ticks, with the first A prescaler cycles 65 ticks long.
- R2: A word with bits [1:0]=00 programs the reference ratio R = bits [16:2]. The reference pulse then repeats every R reference ticks.
- R3: Each output pulse is high for exactly one clock cycle. It is raised in the cycle after the tick that ends the period.
- R4: A new ratio takes effect at the next period boundary. The period in progress when the word is written completes with the old ratio.
- R5: A main word with B < 3 uses B = 3 and sets `err_o`. Any legal main word clears the main error.
- R6: A main word with A >= B or A >= 64 uses A = 0 and sets `err_o`.
- R7: A reference word with R < 3 uses R = 3 and sets `err_o`. A legal reference word clears the reference error.
- R8: A main word with mode bit [20]=1 (reserved) sets `err_o`, and the divider keeps the 64/65 modulus.
- R9: After reset: `err_o`=0, no pulses, main ratio 192 (B=3, A=0), reference ratio 3.
- R10: Words with bits [1:0]=10 or 11 belong to the other loop. They change neither ratio nor `err_o`.
- R11: Clock cycles without a tick do not advance a divider. A stalled stretch lengthens the period in clocks by exactly its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word strobe |
| cfg_word_i | input | 24 | Configuration word |
| main_en_i | input | 1 | One oscillator input cycle |
| ref_en_i | input | 1 | One reference input cycle |
| main_pulse_o | output | 1 | End of main period |
| ref_pulse_o | output | 1 | End of reference period |
| err_o | output | 1 | Last main or reference word was illegal |

## Verification
The hardest case to create is a word written while a period is already running. The check has to show that the period completes with the old ratio, and a measurement that only counts pulse gaps cannot reveal this on its own. The stimulus waits for a main pulse and writes the new word in the very next cycle. It then measures that gap and the following gap separately, expecting the old ratio and then the new one. Counting the swallowed 65-tick cycles is covered by ratios with nonzero A, including the 6348 and 16672 settings.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int WORD_W  = 24;
  localparam int SEL_W   = 2;
  localparam int FLD_LSB = 2;
  localparam int MIN_RATIO = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_REF   = 2'b00,
    SEL_MAIN  = 2'b01,
    SEL_REF2  = 2'b10,
    SEL_MAIN2 = 2'b11
  } sel_e;
endpackage

// File: rtl/swd_cfg.sv
module swd_cfg
  import swd_pkg::*;
#(
  parameter int A_W = 7,
  parameter int B_W = 11,
  parameter int R_W = 15,
  parameter int PRE = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [A_W-1:0]    pend_a_o,
  output logic [B_W-1:0]    pend_b_o,
  output logic [R_W-1:0]    pend_r_o,
  output logic              err_o
);
  localparam int A_LSB = FLD_LSB;
  localparam int B_LSB = A_LSB + A_W;
  localparam int M_BIT = B_LSB + B_W;
  localparam int R_LSB = FLD_LSB;

  sel_e           sel;
  logic [A_W-1:0] a_raw, a_fix;
  logic [B_W-1:0] b_raw, b_fix;
  logic [R_W-1:0] r_raw, r_fix;
  logic           a_bad, b_bad, r_bad, m_bad;
  logic           err_main_q, err_ref_q;

  always_comb begin
    sel   = sel_e'(word_i[SEL_W-1:0]);
    a_raw = word_i[A_LSB +: A_W];
    b_raw = word_i[B_LSB +: B_W];
    r_raw = word_i[R_LSB +: R_W];
    m_bad = word_i[M_BIT];
    b_bad = b_raw < B_W'(MIN_RATIO);
    b_fix = b_bad ? B_W'(MIN_RATIO) : b_raw;
    a_bad = (32'(a_raw) >= 32'(b_fix)) || (32'(a_raw) >= 32'(PRE));
    a_fix = a_bad ? '0 : a_raw;
    r_bad = r_raw < R_W'(MIN_RATIO);
    r_fix = r_bad ? R_W'(MIN_RATIO) : r_raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_a_o   <= '0;
      pend_b_o   <= B_W'(MIN_RATIO);
      pend_r_o   <= R_W'(MIN_RATIO);
      err_main_q <= 1'b0;
      err_ref_q  <= 1'b0;
    end else if (we_i) begin
      if (sel == SEL_MAIN) begin
        pend_a_o   <= a_fix;
        pend_b_o   <= b_fix;
        err_main_q <= a_bad | b_bad | m_bad;
      end else if (sel == SEL_REF) begin
        pend_r_o  <= r_fix;
        err_ref_q <= r_bad;
      end
    end
  end

  assign err_o = err_main_q | err_ref_q;
endmodule

// File: rtl/swd_main_div.sv
module swd_main_div #(
  parameter int A_W = 7,
  parameter int B_W = 11,
  parameter int PRE = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [A_W-1:0] pend_a_i,
  input  logic [B_W-1:0] pend_b_i,
  output logic           pulse_o
);
  localparam int PC_W = $clog2(PRE + 1);

  logic [PC_W-1:0] pre_q;
  logic [A_W-1:0]  a_q;
  logic [B_W-1:0]  b_q;
  logic            swallow, pre_last;

  // 65-tick prescaler cycles while A remains, 64 afterwards
  assign swallow  = (a_q != '0);
  assign pre_last = swallow ? (pre_q == PC_W'(PRE)) : (pre_q == PC_W'(PRE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      a_q     <= '0;
      b_q     <= B_W'(3);
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (en_i) begin
        if (pre_last) begin
          pre_q <= '0;
          if (b_q == B_W'(1)) begin
            pulse_o <= 1'b1;
            b_q     <= pend_b_i;
            a_q     <= pend_a_i;
          end else begin
            b_q <= b_q - B_W'(1);
            if (swallow) a_q <= a_q - A_W'(1);
          end
        end else begin
          pre_q <= pre_q + PC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/swd_ref_div.sv
module swd_ref_div #(
  parameter int R_W = 15
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [R_W-1:0] pend_r_i,
  output logic           pulse_o
);
  logic [R_W-1:0] r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q     <= R_W'(3);
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (en_i) begin
        if (r_q == R_W'(1)) begin
          pulse_o <= 1'b1;
          r_q     <= pend_r_i;
        end else begin
          r_q <= r_q - R_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/swd_top.sv
module swd_top
  import swd_pkg::*;
#(
  parameter int A_W = 7,
  parameter int B_W = 11,
  parameter int R_W = 15,
  parameter int PRE = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_word_i,
  input  logic              main_en_i,
  input  logic              ref_en_i,
  output logic              main_pulse_o,
  output logic              ref_pulse_o,
  output logic              err_o
);
  logic [A_W-1:0] pend_a;
  logic [B_W-1:0] pend_b;
  logic [R_W-1:0] pend_r;

  swd_cfg #(.A_W(A_W), .B_W(B_W), .R_W(R_W), .PRE(PRE)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .word_i(cfg_word_i),
    .pend_a_o(pend_a), .pend_b_o(pend_b), .pend_r_o(pend_r), .err_o(err_o)
  );

  swd_main_div #(.A_W(A_W), .B_W(B_W), .PRE(PRE)) u_main (
    .clk_i, .rst_ni, .en_i(main_en_i),
    .pend_a_i(pend_a), .pend_b_i(pend_b), .pulse_o(main_pulse_o)
  );

  swd_ref_div #(.R_W(R_W)) u_ref (
    .clk_i, .rst_ni, .en_i(ref_en_i), .pend_r_i(pend_r), .pulse_o(ref_pulse_o)
  );
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int B_LSB = 9,
  parameter int B_W   = 11,
  parameter int R_LSB = 2,
  parameter int R_W   = 15,
  parameter int MIN_MAIN = 192
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [23:0] cfg_word_i,
  input logic        main_en_i,
  input logic        ref_en_i,
  input logic        main_pulse_o,
  input logic        ref_pulse_o,
  input logic        err_o
);
  logic [17:0] main_ticks, ref_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_ticks <= '0;
      ref_ticks  <= '0;
    end else begin
      if (main_pulse_o) main_ticks <= {17'd0, main_en_i};
      else if (main_en_i && main_ticks != '1) main_ticks <= main_ticks + 18'd1;
      if (ref_pulse_o) ref_ticks <= {17'd0, ref_en_i};
      else if (ref_en_i && ref_ticks != '1) ref_ticks <= ref_ticks + 18'd1;
    end
  end

  assert_main_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_pulse_o |=> !main_pulse_o);
  assert_ref_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |=> !ref_pulse_o);
  assert_main_needs_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_pulse_o |-> $past(main_en_i));
  assert_bad_b_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_word_i[1:0] == 2'b01 && cfg_word_i[B_LSB +: B_W] < B_W'(3)) |=> err_o);
  assert_bad_r_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_word_i[1:0] == 2'b00 && cfg_word_i[R_LSB +: R_W] < R_W'(3)) |=> err_o);
  assert_main_min_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_pulse_o |-> (main_ticks >= 18'(MIN_MAIN)));
  assert_ref_min_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |-> (ref_ticks >= 18'd3));
endmodule

bind swd_top swd_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_word_i(cfg_word_i),
  .main_en_i(main_en_i), .ref_en_i(ref_en_i), .main_pulse_o(main_pulse_o),
  .ref_pulse_o(ref_pulse_o), .err_o(err_o)
);

// File: tb/swd_top_tb.sv
module swd_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [23:0] word = '0;
  logic        m_en = 1'b0;
  logic        r_en = 1'b0;
  logic        m_pls, r_pls, err;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swd_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_word_i(word),
    .main_en_i(m_en), .ref_en_i(r_en),
    .main_pulse_o(m_pls), .ref_pulse_o(r_pls), .err_o(err)
  );

  function automatic logic [23:0] mk_main(int b, int a, bit mode);
    return {3'b000, mode, 11'(b), 7'(a), 2'b01};
  endfunction
  function automatic logic [23:0] mk_ref(int r);
    return {7'd0, 15'(r), 2'b00};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(logic [23:0] w);
    @(negedge clk); we = 1'b1; word = w;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic gap_main(output int n);
    n = 0;
    do @(negedge clk); while (!m_pls);
    do begin @(negedge clk); n++; end while (!m_pls && n < 200000);
  endtask

  task automatic gap_ref(output int n);
    n = 0;
    do @(negedge clk); while (!r_pls);
    do begin @(negedge clk); n++; end while (!r_pls && n < 200000);
  endtask

  // drop one gap that may hold the previous ratio, then measure
  task automatic main_after_write(string req, logic [23:0] w, int exp_n, int exp_err);
    int n;
    write(w);
    chk({req, " err"}, int'(err), exp_err);
    gap_main(n);
    gap_main(n);
    chk({req, " main period"}, n, exp_n);
  endtask

  task automatic t_reset;
    int n;
    chk("R9 err", int'(err), 0);
    chk("R9 main pulse", int'(m_pls), 0);
    chk("R9 ref pulse", int'(r_pls), 0);
    m_en = 1'b1; r_en = 1'b1;
    gap_main(n); chk("R9 main ratio", n, 192);
    gap_ref(n);  chk("R9 ref ratio", n, 3);
  endtask

  task automatic t_main_ratios;
    main_after_write("R1 b4a1", mk_main(4, 1, 1'b0), 257, 0);
    main_after_write("R1 b99a12", mk_main(99, 12, 1'b0), 6348, 0);
    main_after_write("R1 b260a32", mk_main(260, 32, 1'b0), 16672, 0);
    main_after_write("R1 b3a0", mk_main(3, 0, 1'b0), 192, 0);
  endtask

  task automatic t_ref_ratios;
    int n;
    write(mk_ref(64));
    chk("R2 err", int'(err), 0);
    gap_ref(n); gap_ref(n); chk("R2 r64", n, 64);
    write(mk_ref(5));
    gap_ref(n); gap_ref(n); chk("R2 r5", n, 5);
  endtask

  task automatic t_pulse_width;
    int hi = 0;
    do @(negedge clk); while (!m_pls);
    while (m_pls) begin hi++; @(negedge clk); end
    chk("R3 main width", hi, 1);
    hi = 0;
    do @(negedge clk); while (!r_pls);
    while (r_pls) begin hi++; @(negedge clk); end
    chk("R3 ref width", hi, 1);
  endtask

  task automatic t_boundary;
    int n;
    main_after_write("R4 setup", mk_main(4, 1, 1'b0), 257, 0);
    do @(negedge clk); while (!m_pls);
    we = 1'b1; word = mk_main(5, 2, 1'b0);
    n = 0;
    do begin @(negedge clk); we = 1'b0; n++; end while (!m_pls && n < 200000);
    chk("R4 old ratio holds", n, 257);
    gap_main(n);
    chk("R4 new ratio after boundary", n, 322);
  endtask

  task automatic t_clamps;
    int n;
    main_after_write("R5 b1", mk_main(1, 0, 1'b0), 192, 1);
    main_after_write("R5 clear", mk_main(4, 1, 1'b0), 257, 0);
    main_after_write("R6 a>=b", mk_main(5, 7, 1'b0), 320, 1);
    main_after_write("R6 a>=64", mk_main(100, 64, 1'b0), 6400, 1);
    main_after_write("R8 mode", mk_main(4, 1, 1'b1), 257, 1);
    main_after_write("R8 clear", mk_main(4, 1, 1'b0), 257, 0);
    write(mk_ref(2));
    chk("R7 err r2", int'(err), 1);
    gap_ref(n); gap_ref(n); chk("R7 r2 clamp", n, 3);
    write(mk_ref(0));
    gap_ref(n); gap_ref(n); chk("R7 r0 clamp", n, 3);
    write(mk_ref(7));
    chk("R7 clear", int'(err), 0);
  endtask

  task automatic t_other_sel;
    int n;
    write({3'b000, 1'b0, 11'd9, 7'd0, 2'b10});
    write({7'd0, 15'd1, 2'b11});
    write({3'b000, 1'b1, 11'd0, 7'd99, 2'b11});
    chk("R10 err", int'(err), 0);
    gap_main(n); gap_main(n); chk("R10 main kept", n, 257);
    gap_ref(n); gap_ref(n); chk("R10 ref kept", n, 7);
  endtask

  task automatic t_stall;
    int n;
    do @(negedge clk); while (!m_pls);
    n = 0;
    repeat (10) begin @(negedge clk); n++; end
    m_en = 1'b0;
    repeat (50) begin @(negedge clk); n++; end
    m_en = 1'b1;
    do begin @(negedge clk); n++; end while (!m_pls && n < 200000);
    chk("R11 stall lengthens", n, 257 + 50);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main_ratios();
    t_ref_ratios();
    t_pulse_width();
    t_boundary();
    t_clamps();
    t_other_sel();
    t_stall();
    finish_run();
  end
endmodule